// File: doc/BRIEF.md
# Configurable Serial Audio Receive Port

This block takes two-channel serial audio made of a bit clock, a frame clock and a data line. It delivers each frame as a pair of 24-bit parallel samples with a one-cycle valid strobe. Everything runs in the system clock domain. The serial clocks are treated as slow signals that are synchronised and edge-detected, so the system clock must run at least four times faster than the bit clock.

An 8-bit format word is loaded through `fmtData` when `fmtWrite` pulses, and it sets how the stream is read:

- **Clock ownership:** in slave mode the far end supplies both serial clocks. In master mode the block builds them from a rate enable (`rateTick`), at 64 or 128 bit clocks per frame.
- **Data placement:** the data can be placed from the start of each half-frame, with the first bit optionally skipped. It can also be placed against the end of the half-frame at 16, 20 or 24 bits.
- **Edge and polarity:** the sampling edge and the frame-clock polarity are both selectable.

Each load of the format word drops any frame in progress, and capture restarts on a clean frame boundary.

Top module: `audio_serial_rx`

## Requirements
- R1: After reset the format word is 0x00, `leftSample` and `rightSample` are zero, and `sampleValid`, `bclkOut` and `lrckOut` are low.
- R2: With format bit 7 = 0 (slave), `bclkOut` and `lrckOut` stay low. Audio is taken from `bclkIn`, `lrckIn` and `sdataIn`.
- R3: With bit 7 = 1 (master), `bclkOut` toggles once per `rateTick` cycle. `lrckOut` toggles only together with a launch edge of `bclkOut`, once every 32 launch edges when bit 6 = 0 and once every 64 when bit 6 = 1. The launch edge is the bit-clock edge opposite the sampling edge.
- R4: With bit 3 = 0 (start-placed data), bit 2 = 0 puts the MSB in the first sampled bit after a frame-clock change. Bit 2 = 1 puts it in the second sampled bit.
- R5: With bit 3 = 1 (end-placed data), the word is the last N sampled bits before the next frame-clock change, LSB last. Bits 5:4 set N: 00 gives 24, 01 gives 20, 10 gives 16, and the spare code 11 also gives 24.
- R6: Samples are MSB-aligned in 24 bits, and unused low bits read zero. Start-placed data uses exactly 24 bits, and later bits in the half-frame are ignored.
- R7: Bit 1 = 0 samples data on rising bit-clock edges and bit 1 = 1 on falling edges. The frame clock and data change on the other edge.
- R8: Bit 0 = 0 makes the half-frame with the frame clock high the left channel. Bit 0 = 1 makes it the right channel. A frame is a left half followed by a right half.
- R9: `sampleValid` is high for exactly one cycle after the right half of a frame whose left half was also received. `leftSample` and `rightSample` change only in that cycle.
- R10: A `fmtWrite` discards the frame in progress. No strobe then comes earlier than two half-frames after the write, and the first strobe carries a complete frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fmtData | input | 8 | New format word |
| fmtWrite | input | 1 | Load strobe for the format word |
| rateTick | input | 1 | Master mode: one-cycle enable per bit-clock half period |
| bclkIn | input | 1 | External bit clock (slave) |
| lrckIn | input | 1 | External frame clock (slave) |
| sdataIn | input | 1 | Serial audio data |
| bclkOut | output | 1 | Generated bit clock (master), low in slave |
| lrckOut | output | 1 | Generated frame clock (master), low in slave |
| leftSample | output | 24 | Left channel sample, MSB-aligned |
| rightSample | output | 24 | Right channel sample, MSB-aligned |
| sampleValid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
Faults in the bit index, the channel flag or the alignment shift show up at the next strobe. They appear as a sample pair that matches no transmitted frame, is shifted, or has its channels swapped, so they are seen within one frame of the fault. A wrong frame-tracking state instead shifts when the strobe comes. Either a strobe is missing, or it arrives too early after a format write. The bench catches this by timing the first strobe against the write and by requiring that the received frames follow one another in order.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  localparam int SAMPLE_W = 24;

  // Per-cycle commands from the control to the datapath.
  typedef struct packed {
    logic shiftEn;   // take bitVal into the shift register
    logic bitVal;    // sampled data bit
    logic newHalf;   // this sample opens a new half-frame
    logic takeLeft;  // the half that just closed was a complete left half
    logic commit;    // the half that just closed completes a frame
  } rxStrobe_t;

  // Word length of end-placed data; the spare code falls back to full width.
  function automatic int unsigned rjWidth(input logic [1:0] code);
    case (code)
      2'b01:   return 20;
      2'b10:   return 16;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/audio_rx_clkgen.sv
module audio_rx_clkgen #(
  parameter int HALF_BASE = 32,
  localparam int CNT_W = $clog2(2 * HALF_BASE)
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic wide,
  input  logic launchLvl,
  input  logic rateTick,
  output logic bclkGen,
  output logic lrckGen
);
  logic [CNT_W-1:0] launchCnt;
  logic [CNT_W-1:0] lastCnt;

  assign lastCnt = wide ? CNT_W'(2 * HALF_BASE - 1) : CNT_W'(HALF_BASE - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkGen   <= 1'b0;
      lrckGen   <= 1'b0;
      launchCnt <= '0;
    end else if (!enable) begin
      bclkGen   <= 1'b0;
      lrckGen   <= 1'b0;
      launchCnt <= '0;
    end else if (rateTick) begin
      bclkGen <= ~bclkGen;
      if (~bclkGen == launchLvl) begin
        if (launchCnt >= lastCnt) begin
          launchCnt <= '0;
          lrckGen   <= ~lrckGen;
        end else begin
          launchCnt <= launchCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/audio_rx_ctrl.sv
module audio_rx_ctrl
  import audio_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bclkSrc,
  input  logic       lrckSrc,
  input  logic       sdataSrc,
  input  logic       sampFall,
  input  logic       lrPol,
  input  logic       ljDelay,
  input  logic       rjMode,
  input  logic       fmtWrite,
  output rxStrobe_t  strobe
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [SYNC_STAGES-1:0][2:0] syncQ;
  logic bS, lS, dS, prevB, sampEdge;
  logic primed, lrckLast, inFrame, haveLeft, newHalf, leftCh;
  logic [IDX_W-1:0] bitIdx, idxNext, ljStart, ljEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevB <= 1'b0;
    end else begin
      syncQ[0] <= {bclkSrc, lrckSrc, sdataSrc};
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      prevB <= bS;
    end
  end

  assign bS = syncQ[SYNC_STAGES-1][2];
  assign lS = syncQ[SYNC_STAGES-1][1];
  assign dS = syncQ[SYNC_STAGES-1][0];
  assign sampEdge = sampFall ? (prevB & ~bS) : (~prevB & bS);

  always_comb begin
    newHalf = primed && (lS != lrckLast);
    idxNext = newHalf ? '0 : ((bitIdx == IDX_MAX) ? bitIdx : bitIdx + 1'b1);
    ljStart = {{(IDX_W-1){1'b0}}, ljDelay};
    ljEnd   = ljStart + IDX_W'(SAMPLE_W);
    leftCh  = lrckLast ^ lrPol;
    strobe.bitVal   = dS;
    strobe.shiftEn  = sampEdge && (rjMode || (idxNext >= ljStart && idxNext < ljEnd));
    strobe.newHalf  = sampEdge && newHalf && !fmtWrite;
    strobe.takeLeft = strobe.newHalf && inFrame && leftCh;
    strobe.commit   = strobe.newHalf && inFrame && !leftCh && haveLeft;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed   <= 1'b0;
      lrckLast <= 1'b0;
      inFrame  <= 1'b0;
      haveLeft <= 1'b0;
      bitIdx   <= '0;
    end else if (fmtWrite) begin
      primed   <= 1'b0;
      inFrame  <= 1'b0;
      haveLeft <= 1'b0;
    end else if (sampEdge) begin
      primed   <= 1'b1;
      lrckLast <= lS;
      bitIdx   <= idxNext;
      if (newHalf) inFrame <= 1'b1;
      if (strobe.takeLeft) haveLeft <= 1'b1;
      else if (strobe.commit) haveLeft <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_rx_dp.sv
module audio_rx_dp
  import audio_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobe_t           strobe,
  input  logic                rjMode,
  input  logic [1:0]          rjCode,
  output logic [SAMPLE_W-1:0] leftSample,
  output logic [SAMPLE_W-1:0] rightSample,
  output logic                sampleValid
);
  logic [SAMPLE_W-1:0] shiftQ, leftHold, alignedWord;

  always_comb begin
    if (rjMode) alignedWord = shiftQ << (SAMPLE_W - int'(rjWidth(rjCode)));
    else        alignedWord = shiftQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ      <= '0;
      leftHold    <= '0;
      leftSample  <= '0;
      rightSample <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobe.commit;
      if (strobe.takeLeft) leftHold <= alignedWord;
      if (strobe.commit) begin
        leftSample  <= leftHold;
        rightSample <= alignedWord;
      end
      if (strobe.newHalf)
        shiftQ <= strobe.shiftEn ? {{(SAMPLE_W-1){1'b0}}, strobe.bitVal} : '0;
      else if (strobe.shiftEn)
        shiftQ <= {shiftQ[SAMPLE_W-2:0], strobe.bitVal};
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audio_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HALF_BASE = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          fmtData,
  input  logic                fmtWrite,
  input  logic                rateTick,
  input  logic                bclkIn,
  input  logic                lrckIn,
  input  logic                sdataIn,
  output logic                bclkOut,
  output logic                lrckOut,
  output logic [SAMPLE_W-1:0] leftSample,
  output logic [SAMPLE_W-1:0] rightSample,
  output logic                sampleValid
);
  localparam int IDX_W = $clog2(2 * HALF_BASE) + 1;

  logic [7:0] fmtQ;
  rxStrobe_t  strobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         fmtQ <= 8'h00;
    else if (fmtWrite) fmtQ <= fmtData;
  end

  audio_rx_clkgen #(.HALF_BASE(HALF_BASE)) u_clkgen (
    .clk(clk), .rstN(rstN), .enable(fmtQ[7]), .wide(fmtQ[6]),
    .launchLvl(fmtQ[1]), .rateTick(rateTick),
    .bclkGen(bclkOut), .lrckGen(lrckOut)
  );

  audio_rx_ctrl #(.SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .bclkSrc(fmtQ[7] ? bclkOut : bclkIn),
    .lrckSrc(fmtQ[7] ? lrckOut : lrckIn),
    .sdataSrc(sdataIn),
    .sampFall(fmtQ[1]), .lrPol(fmtQ[0]), .ljDelay(fmtQ[2]), .rjMode(fmtQ[3]),
    .fmtWrite(fmtWrite), .strobe(strobe)
  );

  audio_rx_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rjMode(fmtQ[3]), .rjCode(fmtQ[5:4]),
    .leftSample(leftSample), .rightSample(rightSample), .sampleValid(sampleValid)
  );
endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        masterMode,
  input logic        rjMode,
  input logic [1:0]  rjCode,
  input logic        bclkOut,
  input logic        lrckOut,
  input logic [23:0] leftSample,
  input logic [23:0] rightSample,
  input logic        sampleValid
);
  assert_slave_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(!masterMode) |-> (!bclkOut && !lrckOut));

  assert_frame_on_launch_R3: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && $past(masterMode) && !$stable(lrckOut)) |-> !$stable(bclkOut));

  assert_rj20_pad_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && rjMode && rjCode == 2'b01) |-> (leftSample[3:0] == 4'h0 && rightSample[3:0] == 4'h0));

  assert_rj16_pad_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && rjMode && rjCode == 2'b10) |-> (leftSample[7:0] == 8'h00 && rightSample[7:0] == 8'h00));

  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(leftSample) && $stable(rightSample)));
endmodule

bind audio_serial_rx audio_serial_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .masterMode(fmtQ[7]), .rjMode(fmtQ[3]), .rjCode(fmtQ[5:4]),
  .bclkOut(bclkOut), .lrckOut(lrckOut), .leftSample(leftSample),
  .rightSample(rightSample), .sampleValid(sampleValid)
);

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;
  localparam int TICK = 3;
  localparam int NFR  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] fmtData = 8'h00;
  logic fmtWrite = 1'b0, rateTick = 1'b0;
  logic bclkIn = 1'b0, lrckIn = 1'b0, sdataIn = 1'b0;
  logic bclkOut, lrckOut, sampleValid;
  logic [23:0] leftSample, rightSample;
  int testCnt = 0, failCnt = 0;

  always #4 clk = ~clk;

  audio_serial_rx u_dut (
    .clk(clk), .rstN(rstN), .fmtData(fmtData), .fmtWrite(fmtWrite), .rateTick(rateTick),
    .bclkIn(bclkIn), .lrckIn(lrckIn), .sdataIn(sdataIn), .bclkOut(bclkOut), .lrckOut(lrckOut),
    .leftSample(leftSample), .rightSample(rightSample), .sampleValid(sampleValid)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int wordLen(input logic [7:0] f);
    return (f[5:4] == 2'b01) ? 20 : (f[5:4] == 2'b10) ? 16 : 24;
  endfunction

  function automatic logic [23:0] expWord(input logic [23:0] s, input logic [7:0] f);
    if (!f[3]) return s;
    return s & (24'hFFFFFF << (24 - wordLen(f)));
  endfunction

  function automatic logic txBit(input logic [23:0] s, input int idx, input logic [7:0] f, input int half);
    int d, st;
    if (!f[3]) begin
      d = int'(f[2]);
      if (idx >= d && idx < d + 24) return s[23 - (idx - d)];
      return 1'($urandom);
    end
    st = half - wordLen(f);
    if (idx >= st) return s[23 - (idx - st)];
    return 1'($urandom);
  endfunction

  task automatic runStream(input logic [7:0] f, input bit realign, input string tag);
    logic [23:0] txL [NFR];
    logic [23:0] txR [NFR];
    logic [23:0] rxL [16];
    logic [23:0] rxR [16];
    logic [23:0] s;
    int half, cyc, gCnt, gBit, idx, txFrame, writeCyc, firstDelta, rxCnt, base;
    bit lastB, lastL, curB, curL, leftLvl, isLeft, seenChange, halfOk, quietOk, wrote, gotFirst, pulseOk, prevV;
    for (int i = 0; i < NFR; i++) begin txL[i] = 24'($urandom); txR[i] = 24'($urandom); end
    half = f[6] ? 64 : 32;
    leftLvl = !f[0];
    @(negedge clk); fmtData = f; fmtWrite = 1'b1;
    @(negedge clk); fmtWrite = 1'b0;
    bclkIn = !f[1]; lrckIn = f[0]; sdataIn = 1'b0;
    gCnt = 0; gBit = 0; idx = 0; txFrame = -1; cyc = 0; rxCnt = 0;
    writeCyc = 0; firstDelta = 0;
    seenChange = 0; halfOk = 1; quietOk = 1; wrote = 0; gotFirst = 0; pulseOk = 1; prevV = 0;
    lastB = f[7] ? bclkOut : bclkIn;
    lastL = f[7] ? lrckOut : lrckIn;
    while (txFrame < NFR + 1 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      fmtWrite = 1'b0;
      rateTick = (cyc % TICK == 0);
      if (!f[7]) begin
        gCnt++;
        if (gCnt == TICK) begin
          gCnt = 0;
          bclkIn = !bclkIn;
          if (bclkIn == f[1]) begin
            gBit++;
            if (gBit == half) begin gBit = 0; lrckIn = !lrckIn; end
          end
        end
        if (bclkOut || lrckOut) quietOk = 0;
      end
      curB = f[7] ? bclkOut : bclkIn;
      curL = f[7] ? lrckOut : lrckIn;
      if (curB != lastB && curB == f[1]) begin
        if (curL != lastL) begin
          if (seenChange && idx != half - 1) halfOk = 0;
          seenChange = 1;
          idx = 0;
          if (curL == leftLvl) txFrame++;
        end else idx++;
        lastL = curL;
        isLeft = (curL == leftLvl);
        s = (txFrame >= 0 && txFrame < NFR) ? (isLeft ? txL[txFrame] : txR[txFrame]) : 24'($urandom);
        sdataIn = txBit(s, idx, f, half);
        if (realign && !wrote && txFrame == 1 && isLeft && idx == 2) begin
          fmtData = f; fmtWrite = 1'b1; wrote = 1; writeCyc = cyc; rxCnt = 0;
        end
      end
      lastB = curB;
      if (sampleValid && prevV) pulseOk = 0;
      prevV = sampleValid;
      if (sampleValid && rxCnt < 16) begin
        if (wrote && !gotFirst) begin gotFirst = 1; firstDelta = cyc - writeCyc; end
        rxL[rxCnt] = leftSample; rxR[rxCnt] = rightSample; rxCnt++;
      end
    end
    check(cyc < 20000, {tag, " stream finished"}, 64'(cyc), 64'(20000));
    check(rxCnt >= (realign ? 2 : NFR - 1), {tag, " R9 frame count"}, 64'(rxCnt), 64'(NFR - 1));
    check(pulseOk, {tag, " R9 one-cycle strobe"}, 64'(pulseOk), 64'(1));
    base = -1;
    for (int k = 0; k < rxCnt; k++) begin
      if (k == 0) begin
        for (int j = 0; j < NFR; j++)
          if (base < 0 && rxL[0] == expWord(txL[j], f) && rxR[0] == expWord(txR[j], f)) base = j;
        check(base >= 0, {tag, " first frame matches"}, {16'h0, rxL[0], rxR[0]}, 64'(0));
        if (base < 0) break;
      end else begin
        base++;
        if (base >= NFR) check(0, {tag, " extra frame"}, 64'(base), 64'(NFR - 1));
        else check(rxL[k] == expWord(txL[base], f) && rxR[k] == expWord(txR[base], f),
                   {tag, " frame data"}, {16'h0, rxL[k], rxR[k]},
                   {16'h0, expWord(txL[base], f), expWord(txR[base], f)});
      end
    end
    if (f[7]) check(halfOk, {tag, " R3 frame clock every half-frame"}, 64'(halfOk), 64'(1));
    else      check(quietOk, {tag, " R2 clock outputs low in slave"}, 64'(quietOk), 64'(1));
    if (realign) check(gotFirst && firstDelta >= 2 * half * 2 * TICK, {tag, " R10 strobe delay after write"},
                       64'(firstDelta), 64'(2 * half * 2 * TICK));
  endtask

  initial begin
    int unsigned seedDummy;
    logic [7:0] rf;
    seedDummy = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    check(leftSample == 0 && rightSample == 0, "R1 samples zero", {16'h0, leftSample, rightSample}, 64'(0));
    check(!sampleValid && !bclkOut && !lrckOut, "R1 strobe and clocks low",
          {61'h0, sampleValid, bclkOut, lrckOut}, 64'(0));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!bclkOut && !lrckOut, "R1 R2 default slave", {62'h0, bclkOut, lrckOut}, 64'(0));
    runStream(8'h00, 0, "R4 R7 R8 start-placed no delay");
    runStream(8'h04, 0, "R4 one-bit delay");
    runStream(8'h02, 0, "R7 falling-edge sampling");
    runStream(8'h01, 0, "R8 inverted frame polarity");
    runStream(8'h08, 0, "R5 end-placed 24");
    runStream(8'h18, 0, "R5 R6 end-placed 20");
    runStream(8'h28, 0, "R5 R6 end-placed 16");
    runStream(8'h38, 0, "R5 spare code as 24");
    runStream(8'h40, 0, "R6 start-placed 128 ignores tail");
    runStream(8'h80, 0, "R3 master 64");
    runStream(8'hC4, 0, "R3 R4 master 128 delayed");
    runStream(8'hAB, 0, "R3 R5 R7 R8 master end-placed 16");
    for (int r = 0; r < 3; r++) begin
      rf = 8'($urandom);
      runStream(rf, 0, "R4 R5 R7 R8 random format");
    end
    runStream(8'h00, 1, "R10 realign on write");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt + 1, failCnt + 1);
    $finish;
  end
endmodule